// File: doc/BRIEF.md
# Test Access Port Controller with Core Scan Access

This block is the serial test port of a chip. A single test clock, a mode-select line and a serial data input drive a sixteen-state controller. The controller steps through instruction scans and data scans. A four-bit instruction register picks which data register sits between the serial input and the serial output. The choices are:

- a one-bit pass-through stage;
- a fixed 32-bit identification word;
- a boundary register that samples the pin values and holds the values to be driven out;
- a direct serial path into the core's internal scan chain.

For the core path, the block raises the core's scan-enable for exactly the cycles in which bits move.

Shift stages and the state register advance on the rising test clock. The serial output and its enable change on the falling edge. The instruction and boundary parallel registers are also loaded on the falling edge, in the update states only. This keeps them steady while bits are shifted. Holding the mode-select high for five clocks brings the controller back to its reset state from anywhere. A power-up clear input does the same at power-on.

Top module: `tap_scan_port`

## Requirements
- R1: After power-up clear, the controller is in its reset state: `tdo_oe`, `extest_en` and `core_scan_en` are low, `bsr_q` is zero, and a data scan made without any instruction scan shifts out 32'h149A0001, least significant bit first.
- R2: The instruction register is 4 bits wide. Capture-IR loads 4'b0001, which leaves the serial output least significant bit first during Shift-IR.
- R3: Five consecutive rising edges with `tms` high put the controller in its reset state from any state. The reset state makes the identification instruction (4'b0001) active again.
- R4: Opcode 4'b1111, and every opcode not listed in R2, R5, R6 or R7, selects a one-bit register. That register captures 0 in Capture-DR, so in Shift-DR `tdo` equals `tdi` delayed by one clock.
- R5: Opcode 4'b0010 (sample) loads `pins_in` into the boundary shift stage in Capture-DR and shifts it out least significant bit first. Update-DR copies the shifted-in bits to `bsr_q`, and `extest_en` stays low.
- R6: Opcode 4'b0000 (external test) uses the same boundary register and holds `extest_en` high while it is the active instruction. `bsr_capture` is high in Capture-DR and `bsr_update` is high in Update-DR only while a boundary opcode is active.
- R7: Opcode 4'b1000 (core scan) routes `tdi` to `core_scan_in` and `core_scan_out` to `tdo`. It holds `core_scan_en` high exactly while in Shift-DR, so a chain of N bits is read and reloaded by an N-bit scan.
- R8: `tdo` and `tdo_oe` change only on the falling edge of `tck`. `tdo_oe` is high only in Shift-IR and Shift-DR, and `tdo` is low when not enabled.
- R9: The active instruction changes only on the falling edge in Update-IR or in the reset state. `bsr_q` changes only on the falling edge in Update-DR, so neither moves while bits are being shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Asynchronous power-up clear, active low |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in, sampled on the rising edge |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdo_oe | output | 1 | Output enable for `tdo` |
| pins_in | input | BSR_LEN | Pin values captured by the boundary register |
| bsr_q | output | BSR_LEN | Boundary update register, values to drive on the pins |
| extest_en | output | 1 | External test active: the pins should take `bsr_q` |
| bsr_capture | output | 1 | Boundary capture strobe |
| bsr_update | output | 1 | Boundary update strobe |
| core_scan_en | output | 1 | Scan-enable for the core's internal chain |
| core_scan_in | output | 1 | Serial data into the core chain |
| core_scan_out | input | 1 | Serial data from the end of the core chain |

## Verification
On the rising edge that takes the controller out of Shift-DR or Shift-IR, the last bit of a scan is shifted in. The controller changes state on that same edge. Every scan in the bench ends with its final data bit presented together with `tms` high, so these two events always coincide.

The bench judges this from the outputs of the next steps:
- the value that reaches `bsr_q` after the update;
- the contents of the core chain model;
- the one-clock delay seen through the pass-through stage.

Any of these would be one bit short if the exit edge dropped the shift. A second pairing is the controller's reset and a half-finished instruction scan. The bench enters Shift-IR with external test active, holds `tms` high for five clocks, and then expects the identification word and a low `extest_en`.

// File: rtl/tap_scan_port.sv
module tap_scan_port #(
  parameter int          BSR_LEN = 8,
  parameter logic [31:0] ID_WORD = 32'h149A0001
) (
  input  logic               tck,
  input  logic               por_n,
  input  logic               tms,
  input  logic               tdi,
  output logic               tdo,
  output logic               tdo_oe,
  input  logic [BSR_LEN-1:0] pins_in,
  output logic [BSR_LEN-1:0] bsr_q,
  output logic               extest_en,
  output logic               bsr_capture,
  output logic               bsr_update,
  output logic               core_scan_en,
  output logic               core_scan_in,
  input  logic               core_scan_out
);

  localparam int          IRW        = 4;
  localparam logic [IRW-1:0] OP_EXTEST = 4'b0000;
  localparam logic [IRW-1:0] OP_IDCODE = 4'b0001;
  localparam logic [IRW-1:0] OP_SAMPLE = 4'b0010;
  localparam logic [IRW-1:0] OP_CORE   = 4'b1000;
  localparam logic [IRW-1:0] OP_BYPASS = 4'b1111;
  localparam logic [IRW-1:0] IR_CAPT   = 4'b0001;

  typedef enum logic [3:0] {
    TLR, IDLE, SEL_DR, CAP_DR, SH_DR, EX1_DR, PA_DR, EX2_DR, UPD_DR,
    SEL_IR, CAP_IR, SH_IR, EX1_IR, PA_IR, EX2_IR, UPD_IR
  } tap_st_e;

  typedef enum logic [1:0] {DR_BYP, DR_ID, DR_BSR, DR_CORE} dr_sel_e;

  tap_st_e state, nxt;
  dr_sel_e sel;

  logic [IRW-1:0]     ir_sh, ir_q;
  logic [31:0]        id_sh;
  logic [BSR_LEN-1:0] bsr_sh;
  logic               byp_q;
  logic               tdo_q, oe_q;

  always_comb begin
    case (state)
      TLR:     nxt = tms ? TLR    : IDLE;
      IDLE:    nxt = tms ? SEL_DR : IDLE;
      SEL_DR:  nxt = tms ? SEL_IR : CAP_DR;
      CAP_DR:  nxt = tms ? EX1_DR : SH_DR;
      SH_DR:   nxt = tms ? EX1_DR : SH_DR;
      EX1_DR:  nxt = tms ? UPD_DR : PA_DR;
      PA_DR:   nxt = tms ? EX2_DR : PA_DR;
      EX2_DR:  nxt = tms ? UPD_DR : SH_DR;
      UPD_DR:  nxt = tms ? SEL_DR : IDLE;
      SEL_IR:  nxt = tms ? TLR    : CAP_IR;
      CAP_IR:  nxt = tms ? EX1_IR : SH_IR;
      SH_IR:   nxt = tms ? EX1_IR : SH_IR;
      EX1_IR:  nxt = tms ? UPD_IR : PA_IR;
      PA_IR:   nxt = tms ? EX2_IR : PA_IR;
      EX2_IR:  nxt = tms ? UPD_IR : SH_IR;
      default: nxt = tms ? SEL_DR : IDLE;
    endcase
  end

  always_ff @(posedge tck or negedge por_n)
    if (!por_n) state <= TLR;
    else        state <= nxt;

  always_comb begin
    case (ir_q)
      OP_IDCODE:            sel = DR_ID;
      OP_SAMPLE, OP_EXTEST: sel = DR_BSR;
      OP_CORE:              sel = DR_CORE;
      default:              sel = DR_BYP;
    endcase
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      ir_sh  <= '0;
      id_sh  <= '0;
      bsr_sh <= '0;
      byp_q  <= 1'b0;
    end else begin
      if (state == CAP_IR)     ir_sh <= IR_CAPT;
      else if (state == SH_IR) ir_sh <= {tdi, ir_sh[IRW-1:1]};
      if (state == CAP_DR) begin
        if (sel == DR_ID)  id_sh  <= ID_WORD;
        if (sel == DR_BSR) bsr_sh <= pins_in;
        if (sel == DR_BYP) byp_q  <= 1'b0;
      end else if (state == SH_DR) begin
        if (sel == DR_ID)  id_sh  <= {tdi, id_sh[31:1]};
        if (sel == DR_BSR) bsr_sh <= {tdi, bsr_sh[BSR_LEN-1:1]};
        if (sel == DR_BYP) byp_q  <= tdi;
      end
    end
  end

  always_ff @(negedge tck or negedge por_n) begin
    if (!por_n) begin
      ir_q  <= OP_IDCODE;
      bsr_q <= '0;
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      if (state == TLR)         ir_q <= OP_IDCODE;
      else if (state == UPD_IR) ir_q <= ir_sh;
      if (state == UPD_DR && sel == DR_BSR) bsr_q <= bsr_sh;
      oe_q <= (state == SH_IR) || (state == SH_DR);
      if (state == SH_IR) tdo_q <= ir_sh[0];
      else if (state == SH_DR)
        case (sel)
          DR_ID:   tdo_q <= id_sh[0];
          DR_BSR:  tdo_q <= bsr_sh[0];
          DR_CORE: tdo_q <= core_scan_out;
          default: tdo_q <= byp_q;
        endcase
      else tdo_q <= 1'b0;
    end
  end

  assign tdo          = tdo_q;
  assign tdo_oe       = oe_q;
  assign extest_en    = (ir_q == OP_EXTEST);
  assign bsr_capture  = (state == CAP_DR) && (sel == DR_BSR);
  assign bsr_update   = (state == UPD_DR) && (sel == DR_BSR);
  assign core_scan_en = (state == SH_DR) && (sel == DR_CORE);
  assign core_scan_in = tdi;

  a_r3_five_tms_reset: assert property (@(posedge tck) disable iff (!por_n)
    (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4)) |=> (state == TLR));

  a_r4_bypass_delay: assert property (@(posedge tck) disable iff (!por_n)
    (state == SH_DR && ir_q == OP_BYPASS && $past(state) == SH_DR) |-> (tdo == $past(tdi)));

  a_r7_scan_en_in_shift: assert property (@(posedge tck) disable iff (!por_n)
    core_scan_en |-> tdo_oe);

  a_r8_oe_in_shift_only: assert property (@(posedge tck) disable iff (!por_n)
    tdo_oe == ((state == SH_IR) || (state == SH_DR)));

  a_r9_ir_moves_in_update: assert property (@(posedge tck) disable iff (!por_n)
    !$stable(ir_q) |-> (state == UPD_IR || state == TLR));

  a_r9_bsr_moves_in_update: assert property (@(posedge tck) disable iff (!por_n)
    !$stable(bsr_q) |-> (state == UPD_DR));

endmodule

// File: tb/tb_tap_scan_port.sv
`timescale 1ns/1ps
module tb_tap_scan_port;
  localparam int BL = 8;
  localparam logic [4:0] CHAIN_INIT = 5'b10110;

  logic tck = 1'b0, por_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic tdo, tdo_oe, extest_en, bsr_capture, bsr_update, core_scan_en, core_scan_in, core_scan_out;
  logic [BL-1:0] pins_in = 8'hC3, bsr_q;
  logic [4:0] chain;
  logic chain_load = 1'b1;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic s_tdo, s_oe, s_cap, s_upd, s_sen, cap_seen, upd_seen;

  always #4 tck = ~tck;

  tap_scan_port #(.BSR_LEN(BL)) dut (
    .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .pins_in(pins_in), .bsr_q(bsr_q), .extest_en(extest_en), .bsr_capture(bsr_capture),
    .bsr_update(bsr_update), .core_scan_en(core_scan_en), .core_scan_in(core_scan_in),
    .core_scan_out(core_scan_out));

  always @(posedge tck)
    if (chain_load) chain <= CHAIN_INIT;
    else if (core_scan_en) chain <= {core_scan_in, chain[4:1]};
  assign core_scan_out = chain[0];

  // {opcode, width, data in, expected data out}
  localparam logic [73:0] VEC [0:4] = '{
    {4'b0001, 6'd32, 32'h0000_0000, 32'h149A0001},
    {4'b1111, 6'd8,  32'h0000_00A5, 32'h0000_004A},
    {4'b0101, 6'd8,  32'h0000_003C, 32'h0000_0078},
    {4'b1110, 6'd4,  32'h0000_000B, 32'h0000_0006},
    {4'b0010, 6'd8,  32'h0000_005A, 32'h0000_00C3}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck); @(negedge tck); #1;
    s_tdo = tdo; s_oe = tdo_oe; s_cap = bsr_capture; s_upd = bsr_update; s_sen = core_scan_en;
  endtask

  task automatic ir_scan(input logic [3:0] op, output logic [3:0] cap);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 4; i++) begin
      cap[i] = s_tdo;
      step(i == 3, op[i]);
    end
  endtask

  task automatic ir_update();
    step(1, 0); step(0, 0);
  endtask

  task automatic dr_scan(input int w, input logic [31:0] din, output logic [31:0] dout);
    dout = '0;
    step(1, 0); step(0, 0); cap_seen = s_cap; step(0, 0);
    for (int i = 0; i < w; i++) begin
      dout[i] = s_tdo;
      step(i == w - 1, din[i]);
    end
  endtask

  task automatic dr_update();
    step(1, 0); upd_seen = s_upd; step(0, 0);
  endtask

  task automatic load_ir(input logic [3:0] op);
    logic [3:0] c;
    ir_scan(op, c); ir_update();
  endtask

  initial begin
    logic [31:0] got, m;
    logic [3:0] c;
    repeat (3) @(negedge tck);
    #1 por_n = 1'b1;
    @(negedge tck); #1;
    chain_load = 1'b0;
    check("R1 oe after clear", tdo_oe, 0);
    check("R1 extest_en after clear", extest_en, 0);
    check("R1 core_scan_en after clear", core_scan_en, 0);
    check("R1 bsr_q after clear", bsr_q, 0);
    step(0, 0);
    check("R8 oe low in idle", s_oe, 0);
    dr_scan(32, 32'h0, got); dr_update();
    check("R1 idcode without IR scan", got, 32'h149A0001);

    for (int k = 0; k < 5; k++) begin
      ir_scan(VEC[k][73:70], c); ir_update();
      check($sformatf("R2 capture-IR pattern, vector %0d", k), c, 4'b0001);
      dr_scan(VEC[k][69:64], VEC[k][63:32], got); dr_update();
      m = (VEC[k][69:64] == 6'd32) ? 32'hFFFF_FFFF : ((32'd1 << VEC[k][69:64]) - 1);
      check($sformatf("R1 R4 R5 table vector %0d", k), got & m, VEC[k][31:0]);
    end
    check("R5 bsr_q after sample update", bsr_q, 8'h5A);
    check("R5 extest_en low in sample", extest_en, 0);

    ir_scan(4'b0000, c);
    check("R9 instruction held before Update-IR", extest_en, 0);
    ir_update();
    check("R6 extest_en after Update-IR", extest_en, 1);
    pins_in = 8'h3C;
    dr_scan(8, 32'h96, got);
    check("R6 capture strobe", cap_seen, 1);
    check("R6 pins captured", got, 8'h3C);
    check("R9 bsr_q held before Update-DR", bsr_q, 8'h5A);
    dr_update();
    check("R6 update strobe", upd_seen, 1);
    check("R6 bsr_q after update", bsr_q, 8'h96);

    load_ir(4'b0001);
    dr_scan(32, 32'h0, got); dr_update();
    check("R6 no capture strobe outside boundary", cap_seen, 0);
    check("R6 no update strobe outside boundary", upd_seen, 0);
    check("R9 bsr_q untouched by idcode scan", bsr_q, 8'h96);

    load_ir(4'b1000);
    check("R7 core_scan_en low in idle", s_sen, 0);
    dr_scan(10, 32'h33A, got);
    check("R7 core chain out", got, 32'h356);
    check("R7 core_scan_en low outside shift", core_scan_en, 0);
    dr_update();
    check("R7 core chain reloaded", chain, 5'b11001);

    load_ir(4'b1111);
    step(1, 0); step(0, 0); step(0, 0);
    check("R8 oe high in shift-DR", s_oe, 1);
    check("R4 bypass captures 0", s_tdo, 0);
    tms = 0; tdi = 1;
    @(posedge tck); #1;
    check("R8 tdo steady after rising edge", tdo, 0);
    @(negedge tck); #1;
    check("R8 tdo updated on falling edge", tdo, 1);
    step(1, 0); dr_update();

    load_ir(4'b0000);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0); step(0, 1); step(0, 1);
    repeat (5) step(1, 0);
    check("R3 five-tms reset clears extest", extest_en, 0);
    step(0, 0);
    dr_scan(32, 32'h0, got); dr_update();
    check("R3 idcode active after tms reset", got, 32'h149A0001);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule